// File: doc/BRIEF.md
# Exception Return Legality Checker

This block judges a request to leave an exception handler and resume at a lower privilege level. The request carries the level the handler runs at (1 to 3), the program status word saved at exception entry, the current status word, the return address, and a set of configuration inputs: whether level 2 exists, which levels run with 64-bit registers, the trap-general-exceptions control, the two security-state bits of level 3, the top-byte-ignore enables and the address-range layout of the target regime. One clock after a request the block reports whether the return is legal, the level and register width execution continues in, the status word to install and the address to resume at.

A rejected return does not raise a trap. Execution stays at the current level and width, the illegal-state flag is set in the new status word, and only the condition flags and the interrupt masks are taken from the saved word. The address is passed on unchanged. A legal return installs the saved word, with the software-step flag kept only when single-step is active at the target level.

Top module: `exc_return_check`

Status word fields used (bit positions): NZCV at [31:28], DAIF masks at [9:6], software-step flag at 21, illegal-state flag at 20, Thumb flag at 5, 32-bit state select at 4 (1 = 32-bit), mode at [3:0] for 64-bit state and [4:0] for 32-bit state.

## Requirements
- R1: After reset rsp_valid is 0; each cycle with req_valid high yields exactly one response with rsp_valid high on the next clock.
- R2: With saved bit 4 set (32-bit state), mode [4:0] maps user 0x10 to level 0, hyp 0x1A to level 2, and FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F to level 1, with rsp_wide 0.
- R3: In 32-bit state, monitor 0x16 and every encoding not listed in R2 make the return illegal.
- R4: With saved bit 4 clear, mode bit 1 set is illegal, mode [3:0] equal to 1 is illegal, and otherwise the target level is mode [3:2] with rsp_wide 1.
- R5: A target level above cur_level is illegal, and so is target level 2 while el2_en is 0.
- R6: For a nonzero target level, level_wide[target] differing from the saved word's width (1 = 64-bit) is illegal; a level 0 target is never rejected for width.
- R7: A level 1 target while trap_general is 1 is illegal.
- R8: With cur_level 3, sec_ext 1 and sec_ns 0 the return is illegal whatever the saved word holds.
- R9: An illegal return reports rsp_legal 0, rsp_level = cur_level, rsp_wide 1, rsp_addr = ret_addr, and rsp_status equal to cur_status with [31:28] and [9:6] from the saved word and bit 20 set.
- R10: A legal return reports rsp_legal 1, the decoded level and width, and rsp_status equal to the saved word apart from bit 21.
- R11: For a legal 64-bit return, when tbi_en[ret_addr[55]] is 1, rsp_addr[63:56] becomes eight copies of bit 55 if two_ranges is 1 and zero otherwise; all other bits pass unchanged.
- R12: For a legal 32-bit return, rsp_addr keeps ret_addr[31:0] with bit 0 cleared, also bit 1 cleared when saved bit 5 is 0, and bits [63:32] zero.
- R13: Bit 21 of rsp_status is kept only when step_active is 1 for the level of the response (target level if legal, cur_level if illegal), otherwise cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Return request present this cycle |
| cur_level | input | 2 | Level the handler runs at (1 to 3) |
| saved_word | input | 32 | Status word saved at exception entry |
| cur_status | input | 32 | Status word currently in force |
| ret_addr | input | 64 | Requested return address |
| el2_en | input | 1 | Level 2 is implemented and enabled |
| level_wide | input | 4 | Per level: 1 = 64-bit registers |
| trap_general | input | 1 | Trap-general-exceptions control |
| sec_ext | input | 1 | Level 3 security-state extension bit |
| sec_ns | input | 1 | Level 3 non-secure bit |
| tbi_en | input | 2 | Top-byte-ignore enable, indexed by address bit 55 |
| two_ranges | input | 1 | Target regime has two address ranges |
| step_active | input | 4 | Per level: single-step active |
| rsp_valid | output | 1 | Response present |
| rsp_legal | output | 1 | Return accepted |
| rsp_level | output | 2 | Level execution continues in |
| rsp_wide | output | 1 | 1 = 64-bit state after return |
| rsp_status | output | 32 | New status word |
| rsp_addr | output | 64 | Adjusted resume address |

## Verification
The assertions watch, on every response, the one-cycle latency, that an accepted return never rises above the current level, reaches a disabled level 2 or level 1 under the trap control, that the level 3 security rule always rejects, that a rejected return keeps level, width and address and sets the illegal flag, and that a 32-bit resume address is aligned with a zero upper half. Only the bench scenarios show the exact mode mapping of each encoding, the width comparison, the field merge in the rejected status word, the top-byte rewrite in its three variants and the step-bit handling.

// File: rtl/erl_pkg.sv
package erl_pkg;

    localparam int LVL_W   = 2;
    localparam int LVL_N   = 1 << LVL_W;
    localparam int ST_W    = 32;

    // status word field positions
    localparam int NARROW_BIT  = 4;
    localparam int THUMB_BIT   = 5;
    localparam int MASK_LSB    = 6;
    localparam int MASK_MSB    = 9;
    localparam int ILLEGAL_BIT = 20;
    localparam int STEP_BIT    = 21;
    localparam int FLAG_LSB    = 28;
    localparam int FLAG_MSB    = 31;

    // 32-bit state mode codes
    localparam logic [4:0] M_USR = 5'h10;
    localparam logic [4:0] M_FIQ = 5'h11;
    localparam logic [4:0] M_IRQ = 5'h12;
    localparam logic [4:0] M_SVC = 5'h13;
    localparam logic [4:0] M_ABT = 5'h17;
    localparam logic [4:0] M_HYP = 5'h1A;
    localparam logic [4:0] M_UND = 5'h1B;
    localparam logic [4:0] M_SYS = 5'h1F;

    typedef logic [LVL_W-1:0] level_t;
    typedef logic [ST_W-1:0]  status_t;

    typedef struct packed {
        logic   bad;
        level_t level;
        logic   wide;
    } target_t;

    function automatic status_t keep_mask();
        status_t m;
        m = '0;
        for (int i = 0; i < ST_W; i++) begin
            if ((i >= FLAG_LSB && i <= FLAG_MSB) || (i >= MASK_LSB && i <= MASK_MSB)) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic target_t map_narrow(logic [4:0] m);
        target_t t;
        t.bad   = 1'b0;
        t.wide  = 1'b0;
        t.level = '0;
        case (m)
            M_USR: t.level = level_t'(0);
            M_HYP: t.level = level_t'(2);
            M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: t.level = level_t'(1);
            default: t.bad = 1'b1;
        endcase
        return t;
    endfunction

    function automatic target_t map_wide(logic [3:0] m);
        target_t t;
        t.wide  = 1'b1;
        t.bad   = m[1] || (m == 4'h1);
        t.level = t.bad ? level_t'(0) : level_t'(m[3:2]);
        return t;
    endfunction

endpackage

// File: rtl/erl_mode_decode.sv
module erl_mode_decode
    import erl_pkg::*;
(
    input  logic [4:0] mode_bits,
    output target_t    target
);
    target_t from_narrow;
    target_t from_wide;

    always_comb begin
        from_narrow = map_narrow(mode_bits);
        from_wide   = map_wide(mode_bits[3:0]);
        target      = mode_bits[NARROW_BIT] ? from_narrow : from_wide;
    end
endmodule

// File: rtl/erl_legality.sv
module erl_legality
    import erl_pkg::*;
(
    input  target_t           target,
    input  level_t            cur_level,
    input  logic              el2_en,
    input  logic [LVL_N-1:0]  level_wide,
    input  logic              trap_general,
    input  logic              sec_ext,
    input  logic              sec_ns,
    output logic              legal
);
    logic too_high;
    logic no_el2;
    logic width_clash;
    logic trapped;
    logic bad_security;

    always_comb begin
        too_high     = target.level > cur_level;
        no_el2       = (target.level == level_t'(2)) && !el2_en;
        width_clash  = (target.level != level_t'(0)) && (level_wide[target.level] != target.wide);
        trapped      = (target.level == level_t'(1)) && trap_general;
        bad_security = (cur_level == level_t'(3)) && sec_ext && !sec_ns;
        legal = !(target.bad || too_high || no_el2 || width_clash || trapped || bad_security);
    end
endmodule

// File: rtl/erl_addr_adjust.sv
module erl_addr_adjust #(
    parameter int ADDR_W  = 64,
    parameter int SEL_BIT = 55,
    parameter int TAG_LSB = 56
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wide,
    input  logic              thumb,
    input  logic [1:0]        tbi_en,
    input  logic              two_ranges,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int NW = 32;

    logic              tbi_hit;
    logic              fill_bit;
    logic [ADDR_W-1:0] wide_addr;
    logic [NW-1:0]     low_addr;

    assign tbi_hit  = tbi_en[addr_in[SEL_BIT]];
    assign fill_bit = two_ranges & addr_in[SEL_BIT];

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i >= TAG_LSB) begin : g_tag
            assign wide_addr[i] = tbi_hit ? fill_bit : addr_in[i];
        end else begin : g_pass
            assign wide_addr[i] = addr_in[i];
        end
    end

    always_comb begin
        low_addr    = addr_in[NW-1:0];
        low_addr[0] = 1'b0;
        if (!thumb) begin
            low_addr[1] = 1'b0;
        end
        addr_out = wide ? wide_addr : {{(ADDR_W-NW){1'b0}}, low_addr};
    end
endmodule

// File: rtl/erl_status_form.sv
module erl_status_form
    import erl_pkg::*;
(
    input  logic              legal,
    input  status_t           saved_word,
    input  status_t           cur_status,
    input  level_t            target_level,
    input  level_t            cur_level,
    input  logic [LVL_N-1:0]  step_active,
    output status_t           status_out
);
    localparam status_t KEEP = keep_mask();

    status_t merged;

    always_comb begin
        merged = (saved_word & KEEP) | (cur_status & ~KEEP);
        merged[ILLEGAL_BIT] = 1'b1;
        if (legal) begin
            status_out = saved_word;
            status_out[STEP_BIT] = saved_word[STEP_BIT] & step_active[target_level];
        end else begin
            status_out = merged;
            status_out[STEP_BIT] = merged[STEP_BIT] & step_active[cur_level];
        end
    end
endmodule

// File: rtl/exc_return_check.sv
module exc_return_check
    import erl_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int SEL_BIT = 55,
    parameter int TAG_LSB = 56
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        cur_level,
    input  logic [31:0]       saved_word,
    input  logic [31:0]       cur_status,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              el2_en,
    input  logic [3:0]        level_wide,
    input  logic              trap_general,
    input  logic              sec_ext,
    input  logic              sec_ns,
    input  logic [1:0]        tbi_en,
    input  logic              two_ranges,
    input  logic [3:0]        step_active,
    output logic              rsp_valid,
    output logic              rsp_legal,
    output logic [1:0]        rsp_level,
    output logic              rsp_wide,
    output logic [31:0]       rsp_status,
    output logic [ADDR_W-1:0] rsp_addr
);
    target_t           target;
    logic              legal;
    status_t           new_status;
    logic [ADDR_W-1:0] adj_addr;

    erl_mode_decode u_decode (
        .mode_bits (saved_word[NARROW_BIT:0]),
        .target    (target)
    );

    erl_legality u_legal (
        .target       (target),
        .cur_level    (cur_level),
        .el2_en       (el2_en),
        .level_wide   (level_wide),
        .trap_general (trap_general),
        .sec_ext      (sec_ext),
        .sec_ns       (sec_ns),
        .legal        (legal)
    );

    erl_addr_adjust #(
        .ADDR_W  (ADDR_W),
        .SEL_BIT (SEL_BIT),
        .TAG_LSB (TAG_LSB)
    ) u_addr (
        .addr_in    (ret_addr),
        .wide       (target.wide),
        .thumb      (saved_word[THUMB_BIT]),
        .tbi_en     (tbi_en),
        .two_ranges (two_ranges),
        .addr_out   (adj_addr)
    );

    erl_status_form u_status (
        .legal        (legal),
        .saved_word   (saved_word),
        .cur_status   (cur_status),
        .target_level (target.level),
        .cur_level    (cur_level),
        .step_active  (step_active),
        .status_out   (new_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_legal  <= 1'b0;
            rsp_level  <= '0;
            rsp_wide   <= 1'b0;
            rsp_status <= '0;
            rsp_addr   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_legal  <= legal;
                rsp_level  <= legal ? target.level : cur_level;
                rsp_wide   <= legal ? target.wide : 1'b1;
                rsp_status <= new_status;
                rsp_addr   <= legal ? adj_addr : ret_addr;
            end
        end
    end
endmodule

// File: rtl/exc_return_check_sva.sv
module exc_return_check_sva #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        cur_level,
    input logic [ADDR_W-1:0] ret_addr,
    input logic              el2_en,
    input logic              trap_general,
    input logic              sec_ext,
    input logic              sec_ns,
    input logic              rsp_valid,
    input logic              rsp_legal,
    input logic [1:0]        rsp_level,
    input logic              rsp_wide,
    input logic [31:0]       rsp_status,
    input logic [ADDR_W-1:0] rsp_addr
);
    assert_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && !rst));

    assert_no_raise_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_legal) |->
            (rsp_level <= $past(cur_level)) && !((rsp_level == 2'd2) && !$past(el2_en)));

    assert_trap_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_legal) |-> !((rsp_level == 2'd1) && $past(trap_general)));

    assert_security_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && ($past(cur_level) == 2'd3) && $past(sec_ext && !sec_ns)) |-> !rsp_legal);

    assert_illegal_stays_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_legal) |->
            (rsp_level == $past(cur_level)) && rsp_wide && rsp_status[20] &&
            (rsp_addr == $past(ret_addr)));

    assert_narrow_addr_R12: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_legal && !rsp_wide) |->
            (rsp_addr[0] == 1'b0) && (rsp_addr[ADDR_W-1:32] == '0));
endmodule

bind exc_return_check exc_return_check_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .cur_level    (cur_level),
    .ret_addr     (ret_addr),
    .el2_en       (el2_en),
    .trap_general (trap_general),
    .sec_ext      (sec_ext),
    .sec_ns       (sec_ns),
    .rsp_valid    (rsp_valid),
    .rsp_legal    (rsp_legal),
    .rsp_level    (rsp_level),
    .rsp_wide     (rsp_wide),
    .rsp_status   (rsp_status),
    .rsp_addr     (rsp_addr)
);

// File: tb/exc_return_check_tb_top.sv
module exc_return_check_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  cur_level;
    logic [31:0] saved_word;
    logic [31:0] cur_status;
    logic [63:0] ret_addr;
    logic        el2_en;
    logic [3:0]  level_wide;
    logic        trap_general;
    logic        sec_ext;
    logic        sec_ns;
    logic [1:0]  tbi_en;
    logic        two_ranges;
    logic [3:0]  step_active;
    logic        rsp_valid;
    logic        rsp_legal;
    logic [1:0]  rsp_level;
    logic        rsp_wide;
    logic [31:0] rsp_status;
    logic [63:0] rsp_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        string       tag;
        logic        legal;
        logic [1:0]  lvl;
        logic        wide;
        logic [31:0] st;
        logic [63:0] ad;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    exc_return_check dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .cur_level(cur_level),
        .saved_word(saved_word), .cur_status(cur_status), .ret_addr(ret_addr),
        .el2_en(el2_en), .level_wide(level_wide), .trap_general(trap_general),
        .sec_ext(sec_ext), .sec_ns(sec_ns), .tbi_en(tbi_en), .two_ranges(two_ranges),
        .step_active(step_active), .rsp_valid(rsp_valid), .rsp_legal(rsp_legal),
        .rsp_level(rsp_level), .rsp_wide(rsp_wide), .rsp_status(rsp_status),
        .rsp_addr(rsp_addr)
    );

    // reference model written from the requirements
    function automatic exp_t model(string tag);
        exp_t e;
        logic ok;
        logic [1:0] lvl;
        logic wide;
        logic [31:0] st;
        logic [63:0] ad;
        ok = 1'b1;
        lvl = 2'd0;
        wide = 1'b1;
        if (saved_word[4]) begin
            wide = 1'b0;
            if (saved_word[4:0] == 5'h10) lvl = 2'd0;
            else if (saved_word[4:0] == 5'h1A) lvl = 2'd2;
            else if (saved_word[4:0] == 5'h11 || saved_word[4:0] == 5'h12 ||
                     saved_word[4:0] == 5'h13 || saved_word[4:0] == 5'h17 ||
                     saved_word[4:0] == 5'h1B || saved_word[4:0] == 5'h1F) lvl = 2'd1;
            else ok = 1'b0;
        end else begin
            if (saved_word[1] || saved_word[3:0] == 4'd1) ok = 1'b0;
            else lvl = saved_word[3:2];
        end
        if (ok) begin
            if (lvl > cur_level) ok = 1'b0;
            if (lvl == 2'd2 && !el2_en) ok = 1'b0;
            if (lvl != 2'd0 && level_wide[lvl] != wide) ok = 1'b0;
            if (lvl == 2'd1 && trap_general) ok = 1'b0;
        end
        if (cur_level == 2'd3 && sec_ext && !sec_ns) ok = 1'b0;
        if (ok) begin
            st = saved_word;
            if (!step_active[lvl]) st[21] = 1'b0;
            if (wide) begin
                ad = ret_addr;
                if (tbi_en[ret_addr[55]]) ad[63:56] = two_ranges ? {8{ret_addr[55]}} : 8'h00;
            end else begin
                ad = {32'h0, ret_addr[31:0]};
                ad[0] = 1'b0;
                if (!saved_word[5]) ad[1] = 1'b0;
            end
        end else begin
            st = cur_status;
            st[31:28] = saved_word[31:28];
            st[9:6]   = saved_word[9:6];
            st[20]    = 1'b1;
            if (!step_active[cur_level]) st[21] = 1'b0;
            lvl  = cur_level;
            wide = 1'b1;
            ad   = ret_addr;
        end
        e.tag = tag; e.legal = ok; e.lvl = lvl; e.wide = wide; e.st = st; e.ad = ad;
        return e;
    endfunction

    task automatic fire(string tag);
        @(negedge clk);
        req_valid = 1'b1;
        q.push_back(model(tag));
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic defaults();
        cur_level = 2'd2; saved_word = 32'hA000_0205; cur_status = 32'h5020_0148;
        ret_addr = 64'h0000_0040_0000_1234; el2_en = 1'b1; level_wide = 4'b1111;
        trap_general = 1'b0; sec_ext = 1'b0; sec_ns = 1'b1; tbi_en = 2'b00;
        two_ranges = 1'b0; step_active = 4'b0000;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL R1: response with no request, got valid=%0b expected 0", rsp_valid);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_legal !== e.legal || rsp_level !== e.lvl || rsp_wide !== e.wide ||
                    rsp_status !== e.st || rsp_addr !== e.ad) begin
                    bad++;
                    $display("FAIL %s: got legal=%0b lvl=%0d wide=%0b st=%h ad=%h expected legal=%0b lvl=%0d wide=%0b st=%h ad=%h",
                             e.tag, rsp_legal, rsp_level, rsp_wide, rsp_status, rsp_addr,
                             e.legal, e.lvl, e.wide, e.st, e.ad);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        defaults();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: reset valid got %0b expected 0", rsp_valid);
        end

        // R10 R4: 64-bit return from level 2 to level 1
        fire("R10");
        // R4: mode bit 1 set, mode equal to 1, and level 0 target
        saved_word = 32'h6000_0006; fire("R4");
        saved_word = 32'h6000_0001; fire("R4");
        saved_word = 32'h3000_0000; fire("R4");
        // R5: above current, level 2 without EL2, level 2 with EL2
        defaults(); saved_word = 32'h1000_000C; fire("R5");
        defaults(); cur_level = 2'd3; saved_word = 32'h0000_0009; el2_en = 1'b0; fire("R5");
        el2_en = 1'b1; fire("R5");
        // R6: width clash at level 1; level 0 narrow target exempt
        defaults(); level_wide = 4'b1101; fire("R6");
        defaults(); saved_word = 32'h8000_0010; fire("R6");
        // R7: trap at level 1 rejects, level 0 allowed
        defaults(); trap_general = 1'b1; fire("R7");
        saved_word = 32'h2000_0000; fire("R7");
        // R8: security rule from level 3, then non-secure set
        defaults(); cur_level = 2'd3; sec_ext = 1'b1; sec_ns = 1'b0; fire("R8");
        sec_ns = 1'b1; fire("R8");
        // R2: 32-bit modes
        defaults(); level_wide = 4'b1001; saved_word = 32'h4000_0013; fire("R2");
        saved_word = 32'h4000_011B; fire("R2");
        cur_level = 2'd3; saved_word = 32'h4000_001A; fire("R2");
        // R3: monitor and unlisted encodings
        defaults(); level_wide = 4'b1001; cur_level = 2'd3; saved_word = 32'h4000_0016; fire("R3");
        saved_word = 32'h4000_0014; fire("R3");
        // R9: rejected merge with a busy current status
        defaults(); cur_status = 32'h0F3F_FC3F; saved_word = 32'hF0F0_F3C2; step_active = 4'b0100; fire("R9");
        // R11: top-byte variants
        defaults(); saved_word = 32'h0000_0004; ret_addr = 64'h1280_0000_0000_1000;
        tbi_en = 2'b10; two_ranges = 1'b1; fire("R11");
        two_ranges = 1'b0; fire("R11");
        tbi_en = 2'b01; fire("R11");
        ret_addr = 64'h5A7F_0000_0000_2000; fire("R11");
        // R12: narrow address alignment
        defaults(); level_wide = 4'b1001; ret_addr = 64'hDEAD_BEEF_FFFF_FFFF;
        saved_word = 32'h0000_0033; fire("R12");
        saved_word = 32'h0000_0013; fire("R12");
        // R13: step flag kept or cleared
        defaults(); saved_word = 32'h0020_0005; step_active = 4'b0010; fire("R13");
        step_active = 4'b1101; fire("R13");
        saved_word = 32'h0020_0006; step_active = 4'b0100; fire("R13");

        repeat (4) @(negedge clk);
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R1: pending responses got %0d expected 0", q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule